// File: doc/BRIEF.md
# Segmented Linear Address Generator

This block turns a segment selection, an index and a displacement into a linear address for a core that runs either in a 64-bit mode or in a 32-bit compatibility mode. The caller supplies the cached base of all six segment registers, the 3-bit segment code of the access, the index and displacement values, the mode, and a valid strobe. One clock later the block presents the linear address, a flag marking a non-canonical address, and an output valid.

In 64-bit mode only the two extra data segments keep their base. The others count as base zero. The full 64-bit sum wraps freely, and the only check made is that the result is canonical for the configured virtual-address width. In compatibility mode every segment contributes the low 32 bits of its base. The sum is formed modulo 2^32 and zero-extended, and no fault is raised.

Top module: `seg_linaddr_gen`

## Requirements
- R1: While rst_ni is low, valid_o, canon_fault_o and lin_addr_o are all 0.
- R2: valid_o equals valid_i delayed by one clock. lin_addr_o and canon_fault_o are registered once per accepted request. On a cycle with valid_i low, lin_addr_o keeps its previous value.
- R3: In 64-bit mode (mode64_i = 1) with segment code 0, 1, 2 or 3 (ES, CS, SS, DS), lin_addr_o = (index_i + disp_i) mod 2^64, whatever those bases hold.
- R4: In 64-bit mode with segment code 4 (FS) or 5 (GS), lin_addr_o = (base + index_i + disp_i) mod 2^64. A wrap past 2^64 raises no fault by itself.
- R5: In 64-bit mode canon_fault_o is 1 exactly when bits 63 down to VA_W-1 (VA_W = 48 by default) of the produced address are not all equal.
- R6: In compatibility mode (mode64_i = 0), lin_addr_o = zero-extended (base[31:0] + index_i[31:0] + disp_i[31:0]) mod 2^32 for segment codes 0 to 5. The upper halves of the base, index and displacement have no effect, and canon_fault_o stays 0.
- R7: Segment codes 6 and 7 act as base zero in both modes. The rest of the computation is the one R3 or R6 gives.
- R8: canon_fault_o is 1 only together with valid_o. It is 0 on every cycle where valid_o is 0.
- R9: Segment base k occupies bits k*64+63 down to k*64 of seg_base_i, where k is the segment code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| mode64_i | input | 1 | 1 = 64-bit mode, 0 = compatibility mode |
| seg_i | input | 3 | Segment code: 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS |
| seg_base_i | input | 384 | Six cached segment bases, 64 bits each, code k at slot k |
| index_i | input | 64 | Index value |
| disp_i | input | 64 | Displacement |
| valid_o | output | 1 | Result valid |
| lin_addr_o | output | 64 | Linear address |
| canon_fault_o | output | 1 | Non-canonical address, qualified by valid_o |

## Verification
Wrap of the 64-bit sum and the canonical check can both act on the same request. A wrapped sum can land in canonical space, as when an FS base near the top of memory is added to a small positive index and the result ends near zero. It can also land in the gap, as when a GS base in the negative half is added to an index of minus one and the result falls just below that half. Directed cases of both kinds, and random FS/GS bases mixed from canonical and arbitrary values, are compared against a bench model. The model checks that the fault follows only the canonical rule and never the carry out of bit 63.

// File: rtl/seg_lag_pkg.sv
package seg_lag_pkg;
  localparam int unsigned NUM_SEG = 6;
  localparam int unsigned SEG_W   = 3;

  typedef enum logic [SEG_W-1:0] {
    SEG_ES = 3'd0,
    SEG_CS = 3'd1,
    SEG_SS = 3'd2,
    SEG_DS = 3'd3,
    SEG_FS = 3'd4,
    SEG_GS = 3'd5
  } seg_code_e;

  // segments whose base survives in 64-bit mode
  function automatic bit keeps_base_64(int unsigned k);
    return (k == int'(SEG_FS)) || (k == int'(SEG_GS));
  endfunction
endpackage

// File: rtl/seg_base_sel.sv
module seg_base_sel
  import seg_lag_pkg::*;
#(
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned COMPAT_W = 32,
  localparam int unsigned BASES_W = NUM_SEG * ADDR_W
) (
  input  logic               mode64_i,
  input  logic [SEG_W-1:0]   seg_i,
  input  logic [BASES_W-1:0] bases_i,
  output logic [ADDR_W-1:0]  base_o
);
  logic [ADDR_W-1:0] eff_base [NUM_SEG];

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    logic [ADDR_W-1:0] raw;
    logic [ADDR_W-1:0] low_ext;
    assign raw     = bases_i[k*ADDR_W +: ADDR_W];
    assign low_ext = {{(ADDR_W-COMPAT_W){1'b0}}, raw[COMPAT_W-1:0]};
    if (keeps_base_64(k)) begin : g_keep
      assign eff_base[k] = mode64_i ? raw : low_ext;
    end else begin : g_zero
      assign eff_base[k] = mode64_i ? '0 : low_ext;
    end
  end

  always_comb begin
    base_o = '0;
    for (int unsigned k = 0; k < NUM_SEG; k++) begin
      if (seg_i == SEG_W'(k)) base_o = eff_base[k];
    end
  end
endmodule

// File: rtl/seg_addr_sum.sv
module seg_addr_sum #(
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned COMPAT_W = 32
) (
  input  logic              mode64_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] index_i,
  input  logic [ADDR_W-1:0] disp_i,
  output logic [ADDR_W-1:0] sum_o
);
  logic [ADDR_W-1:0]   full_sum;
  logic [COMPAT_W-1:0] narrow_sum;

  // both sums wrap silently
  assign full_sum   = base_i + index_i + disp_i;
  assign narrow_sum = base_i[COMPAT_W-1:0] + index_i[COMPAT_W-1:0] + disp_i[COMPAT_W-1:0];
  assign sum_o      = mode64_i ? full_sum : {{(ADDR_W-COMPAT_W){1'b0}}, narrow_sum};
endmodule

// File: rtl/seg_canon_chk.sv
module seg_canon_chk #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned VA_W   = 48
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              fault_o
);
  if (VA_W >= ADDR_W) begin : g_full
    assign fault_o = 1'b0;
  end else begin : g_chk
    localparam int unsigned TOP_W = ADDR_W - VA_W + 1;
    logic [TOP_W-1:0] top_bits;
    assign top_bits = addr_i[ADDR_W-1:VA_W-1];
    assign fault_o  = en_i && !((&top_bits) || !(|top_bits));
  end
endmodule

// File: rtl/seg_linaddr_gen.sv
module seg_linaddr_gen
  import seg_lag_pkg::*;
#(
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned VA_W     = 48,
  parameter int unsigned COMPAT_W = 32,
  localparam int unsigned BASES_W = NUM_SEG * ADDR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               mode64_i,
  input  logic [SEG_W-1:0]   seg_i,
  input  logic [BASES_W-1:0] seg_base_i,
  input  logic [ADDR_W-1:0]  index_i,
  input  logic [ADDR_W-1:0]  disp_i,
  output logic               valid_o,
  output logic [ADDR_W-1:0]  lin_addr_o,
  output logic               canon_fault_o
);
  logic [ADDR_W-1:0] sel_base;
  logic [ADDR_W-1:0] sum_c;
  logic              fault_c;
  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic              fault_q;

  seg_base_sel #(.ADDR_W(ADDR_W), .COMPAT_W(COMPAT_W)) u_base (
    .mode64_i (mode64_i),
    .seg_i    (seg_i),
    .bases_i  (seg_base_i),
    .base_o   (sel_base)
  );

  seg_addr_sum #(.ADDR_W(ADDR_W), .COMPAT_W(COMPAT_W)) u_sum (
    .mode64_i (mode64_i),
    .base_i   (sel_base),
    .index_i  (index_i),
    .disp_i   (disp_i),
    .sum_o    (sum_c)
  );

  seg_canon_chk #(.ADDR_W(ADDR_W), .VA_W(VA_W)) u_canon (
    .en_i    (mode64_i),
    .addr_i  (sum_c),
    .fault_o (fault_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      valid_q <= valid_i;
      fault_q <= valid_i && fault_c;
      if (valid_i) addr_q <= sum_c;
    end
  end

  assign valid_o       = valid_q;
  assign lin_addr_o    = addr_q;
  assign canon_fault_o = fault_q;
endmodule

// File: rtl/seg_linaddr_gen_chk.sv
module seg_linaddr_gen_chk #(
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned VA_W     = 48,
  parameter int unsigned COMPAT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              mode64_i,
  input logic [2:0]        seg_i,
  input logic [ADDR_W-1:0] index_i,
  input logic [ADDR_W-1:0] disp_i,
  input logic              valid_o,
  input logic [ADDR_W-1:0] lin_addr_o,
  input logic              canon_fault_o
);
  logic [ADDR_W-1:0] idx_disp;
  assign idx_disp = index_i + disp_i;

  // R1
  always_comb begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (!valid_o && !canon_fault_o && lin_addr_o == '0);
    end
  end

  a_r2_valid_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_valid_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r2_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(lin_addr_o));

  a_r3_zero_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode64_i && (seg_i <= 3'd3)) |=> (lin_addr_o == $past(idx_disp)));

  a_r5_fault_noncanon: assert property (@(posedge clk_i) disable iff (!rst_ni)
    canon_fault_o |-> !((&lin_addr_o[ADDR_W-1:VA_W-1]) || !(|lin_addr_o[ADDR_W-1:VA_W-1])));

  a_r6_compat_no_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !mode64_i) |=> !canon_fault_o);
  a_r6_compat_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !mode64_i) |=> (lin_addr_o[ADDR_W-1:COMPAT_W] == '0));

  a_r8_fault_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    canon_fault_o |-> valid_o);
endmodule

bind seg_linaddr_gen seg_linaddr_gen_chk #(
  .ADDR_W(ADDR_W), .VA_W(VA_W), .COMPAT_W(COMPAT_W)
) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .valid_i       (valid_i),
  .mode64_i      (mode64_i),
  .seg_i         (seg_i),
  .index_i       (index_i),
  .disp_i        (disp_i),
  .valid_o       (valid_o),
  .lin_addr_o    (lin_addr_o),
  .canon_fault_o (canon_fault_o)
);

// File: tb/seg_linaddr_gen_tb_top.sv
module seg_linaddr_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 64;
  localparam int VA_W       = 48;
  localparam int NSEG       = 6;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   valid_i = 1'b0;
  logic                   mode64 = 1'b0;
  logic [2:0]             seg = 3'd0;
  logic [NSEG*ADDR_W-1:0] bases = '0;
  logic [ADDR_W-1:0]      idx = '0;
  logic [ADDR_W-1:0]      disp = '0;
  logic                   valid_o;
  logic [ADDR_W-1:0]      lin_addr;
  logic                   fault;

  int n_checks = 0;
  int n_errs   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_linaddr_gen dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .valid_i       (valid_i),
    .mode64_i      (mode64),
    .seg_i         (seg),
    .seg_base_i    (bases),
    .index_i       (idx),
    .disp_i        (disp),
    .valid_o       (valid_o),
    .lin_addr_o    (lin_addr),
    .canon_fault_o (fault)
  );

  function automatic logic [63:0] model_addr(bit m, logic [2:0] s, logic [NSEG*64-1:0] b,
                                             logic [63:0] ix, logic [63:0] d);
    logic [63:0] bb;
    logic [31:0] lo;
    bb = (s < 3'd6) ? b[s*64 +: 64] : 64'd0;
    if (m) begin
      if (!(s == 3'd4 || s == 3'd5)) bb = 64'd0;
      return bb + ix + d;
    end
    lo = bb[31:0] + ix[31:0] + d[31:0];
    return {32'd0, lo};
  endfunction

  function automatic bit model_fault(bit m, logic [63:0] a);
    logic [63:0] hi;
    hi = a >> (VA_W - 1);
    if (!m) return 1'b0;
    return !(hi == 64'd0 || hi == ((64'd1 << (64 - VA_W + 1)) - 1));
  endfunction

  function automatic logic [63:0] rand64(int kind);
    logic [63:0] v;
    v = {$urandom, $urandom};
    case (kind)
      0: return {16'h0000, 1'b0, v[46:0]};
      1: return {16'hffff, 1'b1, v[46:0]};
      2: return {{32{v[31]}}, v[31:0]};
      default: return v;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_base(input int k, input logic [63:0] v);
    bases[k*64 +: 64] = v;
  endtask

  // drive at negedge, sample at next negedge (one register stage)
  task automatic run_op(input bit m, input logic [2:0] s, input logic [63:0] ix,
                        input logic [63:0] d, input string req);
    logic [63:0] ea;
    bit ef;
    valid_i = 1'b1; mode64 = m; seg = s; idx = ix; disp = d;
    ea = model_addr(m, s, bases, ix, d);
    ef = model_fault(m, ea);
    @(negedge clk);
    check(valid_o === 1'b1, "R2", "valid_o", {63'd0, valid_o}, 64'd1);
    check(lin_addr === ea, req, "lin_addr", lin_addr, ea);
    check(fault === ef, ef ? "R5" : req, "fault", {63'd0, fault}, {63'd0, ef});
  endtask

  task automatic run_idle();
    logic [63:0] prev;
    prev = lin_addr;
    valid_i = 1'b0;
    idx = rand64(3); disp = rand64(3); mode64 = 1'b1; seg = 3'd4;
    @(negedge clk);
    check(valid_o === 1'b0, "R2", "idle valid_o", {63'd0, valid_o}, 64'd0);
    check(lin_addr === prev, "R2", "idle hold", lin_addr, prev);
    check(fault === 1'b0, "R8", "idle fault", {63'd0, fault}, 64'd0);
  endtask

  function automatic string tag_of(bit m, logic [2:0] s);
    if (s > 3'd5) return "R7";
    if (!m) return "R6";
    return (s >= 3'd4) ? "R4" : "R3";
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < NSEG; k++) set_base(k, 64'hdead_0000_0000_0000 | 64'(k) << 12);
    valid_i = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    check(valid_o === 1'b0, "R1", "reset valid_o", {63'd0, valid_o}, 64'd0);
    check(lin_addr === 64'd0, "R1", "reset lin_addr", lin_addr, 64'd0);
    check(fault === 1'b0, "R1", "reset fault", {63'd0, fault}, 64'd0);
    valid_i = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R3: bases of ES/CS/SS/DS ignored in 64-bit mode
    set_base(3, 64'h1234_5678_9abc_def0);
    set_base(1, 64'hffff_ffff_ffff_ffff);
    run_op(1'b1, 3'd3, 64'h0000_0000_0001_0000, 64'h10, "R3");
    run_op(1'b1, 3'd1, 64'h0000_0000_0000_4000, 64'h8, "R3");
    run_op(1'b1, 3'd2, 64'h0000_0000_0000_0000, 64'h0, "R3");

    // R4 + R9: FS slot 4, GS slot 5; wrap to canonical gives no fault
    set_base(4, 64'hffff_ffff_ffff_fff0);
    run_op(1'b1, 3'd4, 64'h20, 64'h0, "R4");
    set_base(5, 64'h0000_1000_0000_0000);
    run_op(1'b1, 3'd5, 64'h100, 64'h4, "R9");

    // R5: crossing into the non-canonical gap, both directions
    set_base(4, 64'h0000_7fff_ffff_fff0);
    run_op(1'b1, 3'd4, 64'h20, 64'h0, "R5");
    set_base(5, 64'hffff_8000_0000_0000);
    run_op(1'b1, 3'd5, 64'hffff_ffff_ffff_ffff, 64'h0, "R5");
    set_base(5, 64'hffff_8000_0000_0000);
    run_op(1'b1, 3'd5, 64'h0, 64'h0, "R5");

    // R8: fault clears when next request is idle
    set_base(4, 64'h0000_7fff_ffff_fff0);
    run_op(1'b1, 3'd4, 64'h20, 64'h0, "R5");
    run_idle();

    // R6: upper halves ignored, 32-bit wrap, no fault
    set_base(4, 64'hdead_beef_0000_0010);
    run_op(1'b0, 3'd4, 64'hffff_ffff_ffff_fff0, 64'h4, "R6");
    set_base(0, 64'h8000_0000_ffff_ff00);
    run_op(1'b0, 3'd0, 64'h7777_0000_0000_0200, 64'h0, "R6");

    // R7: codes 6 and 7
    run_op(1'b1, 3'd6, 64'h0000_7fff_ffff_0000, 64'h1_0000, "R7");
    run_op(1'b0, 3'd7, 64'hffff_0000_1234_5678, 64'h8, "R7");

    // random mix with idle gaps
    for (int i = 0; i < 400; i++) begin
      logic [2:0] s;
      bit m;
      for (int k = 0; k < NSEG; k++) set_base(k, rand64($urandom_range(0, 3)));
      s = 3'($urandom_range(0, 7));
      m = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 9) == 0) run_idle();
      run_op(m, s, rand64($urandom_range(0, 3)), rand64(2), tag_of(m, s));
    end

    valid_i = 1'b0;
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule